// File: doc/BRIEF.md
# Single-Bus Accumulator Core

This block is a small accumulator processor built around one shared internal bus. Its registers are a program counter, an instruction register, a memory address register, a memory buffer register, the accumulator and an ALU operand register. The ALU takes its first operand straight from the accumulator. Its second operand comes from the bus. Each cycle, a control state machine picks at most one bus source and any number of destinations, so all transfers happen one after another.

The core reads a synchronous, word-addressed memory. It drives an address from the memory address register and a read strobe. The data for a strobe arrives on the read-data port in the following cycle. A one-cycle retire pulse marks the end of each instruction, and a halted flag marks the stop state, so that a bench or a host can line up with the core. The instruction word holds the opcode in its top four bits and the operand address in its low `ADDR_W` bits. Any bits between the two fields are ignored.

Top module: `acc_core`

## Requirements
- R1: While reset is held and until the first fetch, pc_value and acc_value read 0, and halted, retire and mem_rd read 0. The first read after reset uses address 0.
- R2: In any cycle in which a register loads from the bus, exactly one bus source is selected.
- R3: Fetch moves PC over the bus into the address register and then strobes mem_rd with mem_addr equal to PC. The returned word goes into the instruction register. The opcode is bits [15:12] and the operand address is bits [7:0]. Bits [11:8] have no effect.
- R4: Memory-operand ALU opcodes combine AC with M[operand] modulo 2^16 and write the result to AC. The opcodes are 1 add, 2 subtract (AC minus operand), 3 AND, 4 OR, 5 XOR and 8 NOT of the operand. The ALU function codes are 000 add, 001 subtract, 010 AND, 011 OR, 100 XOR, 101 NOT A, 110 pass A and 111 NOT B.
- R5: Opcode 6 replaces AC with its bitwise inverse.
- R6: Opcode 7 loads AC with M[operand], carried over the bus from the buffer register.
- R7: Measured between successive retire pulses, instruction lengths are fixed. Opcodes 1 to 5 and 8 take 10 cycles, opcode 7 takes 9, opcode 6 takes 6, and every other retiring opcode takes 5.
- R8: Opcode 9 sets PC to the operand address.
- R9: Opcode A branches to the operand when AC is zero. Opcode B branches when AC bit 15 is set. When the branch is not taken, PC becomes PC+1.
- R10: Opcodes 0, C, D and E leave AC unchanged and advance PC by one.
- R11: Opcode F raises halted permanently. PC stays at the halt word, and no further reads or retire pulses occur.
- R12: retire is high for one cycle per completed instruction. In that cycle, acc_value and pc_value already show that instruction's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Read address (memory address register) |
| mem_rd | output | 1 | Read strobe; data expected next cycle |
| mem_rdata | input | DATA_W | Read data from memory |
| acc_value | output | DATA_W | Accumulator contents |
| pc_value | output | ADDR_W | Program counter contents |
| retire | output | 1 | One-cycle pulse per completed instruction |
| halted | output | 1 | Core has executed a halt |

## Verification
One straight-line program runs through every opcode. The add operand produces a carry out of bit 15, and subtracting 1 from zero wraps to all ones. The two bitwise operands overlap only in part, so AND, OR and XOR give three different results. Each conditional branch runs once taken and once not taken, using an accumulator that is either zero or has its top bit set; this tells the two branch conditions apart from each other and from an unconditional jump. The jump word and the undefined opcodes carry non-zero filler bits, which shows that the decoder looks only at the opcode and operand fields. The spacing between retire pulses separates the memory-operand, load, register-only and control-flow sequences.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [2:0] {
    ALU_ADD   = 3'b000,
    ALU_SUB   = 3'b001,
    ALU_AND   = 3'b010,
    ALU_OR    = 3'b011,
    ALU_XOR   = 3'b100,
    ALU_NOTA  = 3'b101,
    ALU_PASSA = 3'b110,
    ALU_NOTB  = 3'b111
  } alu_op_e;

  localparam logic [3:0] OP_NOP  = 4'h0;
  localparam logic [3:0] OP_ADD  = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_AND  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_XOR  = 4'h5;
  localparam logic [3:0] OP_INV  = 4'h6;
  localparam logic [3:0] OP_LOAD = 4'h7;
  localparam logic [3:0] OP_NOTM = 4'h8;
  localparam logic [3:0] OP_JUMP = 4'h9;
  localparam logic [3:0] OP_BZ   = 4'hA;
  localparam logic [3:0] OP_BNEG = 4'hB;
  localparam logic [3:0] OP_STOP = 4'hF;

  localparam int OPC_W   = 4;
  localparam int SRC_PC  = 0;
  localparam int SRC_IRA = 1;
  localparam int SRC_AC  = 2;
  localparam int SRC_MBR = 3;
  localparam int SRC_ALU = 4;
  localparam int NSRC    = 5;

  typedef enum logic [3:0] {
    ST_INIT, ST_F1, ST_F2, ST_F3, ST_DEC,
    ST_O1, ST_O2, ST_O3, ST_LD, ST_X1, ST_X2,
    ST_BR, ST_INC, ST_HALT
  } ctrl_state_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] alu_calc(alu_op_e f, logic [W-1:0] x, logic [W-1:0] z);
    unique case (f)
      ALU_ADD:   return x + z;
      ALU_SUB:   return x - z;
      ALU_AND:   return x & z;
      ALU_OR:    return x | z;
      ALU_XOR:   return x ^ z;
      ALU_NOTA:  return ~x;
      ALU_PASSA: return x;
      default:   return ~z;
    endcase
  endfunction

  assign y = alu_calc(op, a, b);

endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux #(
  parameter int W = 16,
  parameter int N = 5
) (
  input  logic [N-1:0]        sel_oh,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        bus
);

  logic [N-1:0][W-1:0] gated;

  for (genvar gi = 0; gi < N; gi++) begin : g_gate
    assign gated[gi] = src[gi] & {W{sel_oh[gi]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic            ac_zero,
  input  logic            ac_neg,
  output logic [NSRC-1:0] src_oh,
  output logic            ld_pc,
  output logic            pc_inc,
  output logic            ld_ac,
  output logic            ld_bop,
  output logic            ld_mar,
  output logic            ld_ir,
  output logic            ld_mbr,
  output logic            mem_rd,
  output logic            fetch_rd,
  output alu_op_e         alu_op,
  output logic            retire_set,
  output logic            halted
);

  ctrl_state_e state_q, state_d;

  function automatic alu_op_e alu_for(logic [OPC_W-1:0] op);
    case (op)
      OP_SUB:  return ALU_SUB;
      OP_AND:  return ALU_AND;
      OP_OR:   return ALU_OR;
      OP_XOR:  return ALU_XOR;
      OP_INV:  return ALU_NOTA;
      OP_NOTM: return ALU_NOTB;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic ctrl_state_e after_decode(logic [OPC_W-1:0] op, logic z, logic n);
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOTM, OP_LOAD: return ST_O1;
      OP_INV:  return ST_X2;
      OP_JUMP: return ST_BR;
      OP_BZ:   return z ? ST_BR : ST_INC;
      OP_BNEG: return n ? ST_BR : ST_INC;
      OP_STOP: return ST_HALT;
      default: return ST_INC;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    src_oh     = '0;
    ld_pc      = 1'b0;
    pc_inc     = 1'b0;
    ld_ac      = 1'b0;
    ld_bop     = 1'b0;
    ld_mar     = 1'b0;
    ld_ir      = 1'b0;
    ld_mbr     = 1'b0;
    mem_rd     = 1'b0;
    retire_set = 1'b0;
    unique case (state_q)
      ST_INIT: state_d = ST_F1;
      ST_F1: begin
        src_oh[SRC_PC] = 1'b1;
        ld_mar  = 1'b1;
        state_d = ST_F2;
      end
      ST_F2: begin
        mem_rd  = 1'b1;
        state_d = ST_F3;
      end
      ST_F3: begin
        ld_ir   = 1'b1;
        state_d = ST_DEC;
      end
      ST_DEC: state_d = after_decode(opcode, ac_zero, ac_neg);
      ST_O1: begin
        src_oh[SRC_IRA] = 1'b1;
        ld_mar  = 1'b1;
        state_d = ST_O2;
      end
      ST_O2: begin
        mem_rd  = 1'b1;
        state_d = ST_O3;
      end
      ST_O3: begin
        ld_mbr  = 1'b1;
        state_d = (opcode == OP_LOAD) ? ST_LD : ST_X1;
      end
      ST_LD: begin
        src_oh[SRC_MBR] = 1'b1;
        ld_ac   = 1'b1;
        state_d = ST_INC;
      end
      ST_X1: begin
        src_oh[SRC_MBR] = 1'b1;
        ld_bop  = 1'b1;
        state_d = ST_X2;
      end
      ST_X2: begin
        src_oh[SRC_ALU] = 1'b1;
        ld_ac   = 1'b1;
        state_d = ST_INC;
      end
      ST_BR: begin
        src_oh[SRC_IRA] = 1'b1;
        ld_pc      = 1'b1;
        retire_set = 1'b1;
        state_d    = ST_F1;
      end
      ST_INC: begin
        pc_inc     = 1'b1;
        retire_set = 1'b1;
        state_d    = ST_F1;
      end
      default: state_d = ST_HALT;
    endcase
  end

  assign alu_op   = alu_for(opcode);
  assign fetch_rd = (state_q == ST_F2);
  assign halted   = (state_q == ST_HALT);

  // R2
  bus_one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc || ld_ac || ld_bop || ld_mar) |-> $onehot(src_oh));

  // R7
  operand_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_O1) |=> (state_q == ST_O2));

  // R7
  exec_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_X1) |=> (state_q == ST_X2));

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !retire_set));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_value,
  output logic [ADDR_W-1:0] pc_value,
  output logic              retire,
  output logic              halted
);

  localparam int PAD_W = DATA_W - ADDR_W;
  localparam logic [DATA_W-1:0] OPER_MASK = {{PAD_W{1'b0}}, {ADDR_W{1'b1}}};

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mbr_q, ac_q, bop_q;
  logic              retire_q;

  logic [NSRC-1:0]             src_oh;
  logic [NSRC-1:0][DATA_W-1:0] bus_src;
  logic [DATA_W-1:0]           bus;
  logic [DATA_W-1:0]           alu_y;
  logic [DATA_W-1:0]           ir_oper;
  alu_op_e                     alu_op;
  logic ld_pc, pc_inc, ld_ac, ld_bop, ld_mar, ld_ir, ld_mbr;
  logic fetch_rd, retire_set;

  function automatic logic [ADDR_W-1:0] pc_step(logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  assign ir_oper = ir_q & OPER_MASK;

  acc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (ir_q[DATA_W-1 -: OPC_W]),
    .ac_zero   (ac_q == '0),
    .ac_neg    (ac_q[DATA_W-1]),
    .src_oh    (src_oh),
    .ld_pc     (ld_pc),
    .pc_inc    (pc_inc),
    .ld_ac     (ld_ac),
    .ld_bop    (ld_bop),
    .ld_mar    (ld_mar),
    .ld_ir     (ld_ir),
    .ld_mbr    (ld_mbr),
    .mem_rd    (mem_rd),
    .fetch_rd  (fetch_rd),
    .alu_op    (alu_op),
    .retire_set(retire_set),
    .halted    (halted)
  );

  always_comb begin
    bus_src          = '0;
    bus_src[SRC_PC]  = {{PAD_W{1'b0}}, pc_q};
    bus_src[SRC_IRA] = ir_oper;
    bus_src[SRC_AC]  = ac_q;
    bus_src[SRC_MBR] = mbr_q;
    bus_src[SRC_ALU] = alu_y;
  end

  acc_bus_mux #(.W(DATA_W), .N(NSRC)) u_bus (
    .sel_oh(src_oh),
    .src   (bus_src),
    .bus   (bus)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op(alu_op),
    .a (ac_q),
    .b (bop_q),
    .y (alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      mar_q    <= '0;
      ir_q     <= '0;
      mbr_q    <= '0;
      ac_q     <= '0;
      bop_q    <= '0;
      retire_q <= 1'b0;
    end else begin
      if (ld_pc)       pc_q <= bus[ADDR_W-1:0];
      else if (pc_inc) pc_q <= pc_step(pc_q);
      if (ld_mar) mar_q <= bus[ADDR_W-1:0];
      if (ld_ir)  ir_q  <= mem_rdata;
      if (ld_mbr) mbr_q <= mem_rdata;
      if (ld_ac)  ac_q  <= bus;
      if (ld_bop) bop_q <= bus;
      retire_q <= retire_set;
    end
  end

  assign mem_addr  = mar_q;
  assign acc_value = ac_q;
  assign pc_value  = pc_q;
  assign retire    = retire_q;

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rd |-> (mem_addr == pc_q));

  // R8
  pc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pc |=> (pc_q == $past(ir_q[ADDR_W-1:0])));

  // R4
  acc_from_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ac && src_oh[SRC_ALU]) |=> (ac_q == $past(alu_y)));

  // R12
  retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] acc_value;
  logic [AW-1:0] pc_value;
  logic          retire;
  logic          halted;

  logic [DW-1:0] mem [0:255];

  typedef struct {
    logic [DW-1:0] acc;
    logic [AW-1:0] pc;
    int            cycles;
    logic [3:0]    op;
  } exp_t;

  exp_t          sbq[$];
  logic [DW-1:0] m_ac;
  logic [AW-1:0] m_pc;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_cyc = -1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .acc_value(acc_value), .pc_value(pc_value),
    .retire(retire), .halted(halted)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8: return "R4";
      4'h6: return "R5";
      4'h7: return "R6";
      4'h9: return "R8";
      4'hA, 4'hB: return "R9";
      default: return "R10";
    endcase
  endfunction

  // driver: assembles one instruction and pushes its expected outcome
  task automatic emit(input logic [3:0] op, input logic [7:0] arg, input logic [3:0] pad);
    exp_t e;
    logic [DW-1:0] opnd;
    int len;
    mem[m_pc] = {op, pad, arg};
    opnd = mem[arg];
    len = 5;
    case (op)
      4'h1: begin m_ac = m_ac + opnd;           len = 10; end
      4'h2: begin m_ac = m_ac + ~opnd + 16'd1;  len = 10; end
      4'h3: begin m_ac = ~(~m_ac | ~opnd);      len = 10; end
      4'h4: begin m_ac = ~(~m_ac & ~opnd);      len = 10; end
      4'h5: begin m_ac = (m_ac | opnd) & ~(m_ac & opnd); len = 10; end
      4'h6: begin m_ac = m_ac ^ 16'hFFFF;       len = 6;  end
      4'h7: begin m_ac = opnd;                  len = 9;  end
      4'h8: begin m_ac = opnd ^ 16'hFFFF;       len = 10; end
      default: ;
    endcase
    if (op == 4'h9 || (op == 4'hA && m_ac == 0) || (op == 4'hB && m_ac[DW-1]))
      m_pc = arg;
    else
      m_pc = m_pc + 8'd1;
    e.acc = m_ac; e.pc = m_pc; e.cycles = len; e.op = op;
    sbq.push_back(e);
  endtask

  // monitor: compares each retired instruction against the queue (R12, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (retire) begin
        if (sbq.size() == 0) begin
          chk("R12", "unexpected retire", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(tag_of(e.op), "acc", acc_value, e.acc);
          chk(tag_of(e.op), "pc", pc_value, e.pc);
          if (last_cyc >= 0) chk("R7", "cycles", cyc - last_cyc, e.cycles);
          last_cyc = cyc;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog actual=running expected=halted");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'hE0] = 16'h1234; mem[8'hE1] = 16'hF00F; mem[8'hE2] = 16'h0250;
    mem[8'hE3] = 16'h0FF0; mem[8'hE4] = 16'h8001; mem[8'hE5] = 16'hFFFF;
    mem[8'hE6] = 16'h00FF; mem[8'hE7] = 16'h0000; mem[8'hE8] = 16'h0001;
    m_ac = '0; m_pc = '0;
    emit(4'h7, 8'hE0, 4'h0);  // R6 load
    emit(4'h1, 8'hE1, 4'h0);  // R4 add with carry out
    emit(4'h2, 8'hE2, 4'h0);  // R4 subtract going negative
    emit(4'h3, 8'hE3, 4'h0);  // R4 and
    emit(4'h4, 8'hE4, 4'h0);  // R4 or
    emit(4'h5, 8'hE5, 4'h0);  // R4 xor
    emit(4'h6, 8'h00, 4'h0);  // R5 invert
    emit(4'h8, 8'hE6, 4'h0);  // R4 not operand
    emit(4'hA, 8'h30, 4'h0);  // R9 zero branch not taken
    emit(4'hB, 8'h20, 4'h0);  // R9 negative branch taken
    emit(4'hC, 8'h55, 4'h7);  // R10 undefined
    emit(4'h0, 8'h00, 4'h0);  // R10 nop
    emit(4'h7, 8'hE7, 4'h0);  // R6 load zero
    emit(4'hB, 8'h50, 4'h0);  // R9 negative branch not taken
    emit(4'hA, 8'h40, 4'h0);  // R9 zero branch taken
    emit(4'h9, 8'h60, 4'hF);  // R8 jump, filler bits R3
    emit(4'h2, 8'hE8, 4'h0);  // R4 0-1 wraps
    emit(4'h1, 8'hE8, 4'h0);  // R4 back to 0
    emit(4'hD, 8'hE0, 4'hA);  // R10
    emit(4'hE, 8'hE1, 4'h5);  // R10
    mem[m_pc] = 16'hF000;     // R11 halt

    repeat (3) @(negedge clk);
    chk("R1", "reset acc", acc_value, 32'd0);
    chk("R1", "reset pc", pc_value, 32'd0);
    chk("R1", "reset halted", halted, 32'd0);
    chk("R1", "reset retire", retire, 32'd0);
    chk("R1", "reset mem_rd", mem_rd, 32'd0);
    rst_n = 1'b1;
    while (!mem_rd) @(negedge clk);
    chk("R1", "first fetch address", mem_addr, 32'd0);

    for (int k = 0; k < 5000 && !halted; k++) @(negedge clk);
    chk("R11", "halted", halted, 32'd1);
    chk("R11", "halt pc", pc_value, m_pc);
    chk("R11", "final acc", acc_value, m_ac);
    chk("R11", "queue drained", sbq.size(), 32'd0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_rd !== 1'b0 || retire !== 1'b0 || halted !== 1'b1 || pc_value !== m_pc)
        chk("R11", "halt hold", {mem_rd, retire, halted, pc_value}, {3'b001, m_pc});
    end
    chk("R11", "halt hold end", {mem_rd, retire, halted, pc_value}, {3'b001, m_pc});
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule